// File: doc/BRIEF.md
# Serial Complex Arithmetic Unit

This block adds, subtracts or multiplies two complex numbers whose real and imaginary parts arrive as separate signed two's-complement words. Instead of one datapath per operation, it owns a single pipelined multiplier and a single adder/subtracter. A control state machine steps through each operation, and multiplexers route the registered operands or the registered partial products to whichever unit the current step needs. This keeps the area to one unit of each kind, at the cost of several cycles per result.

A request is made by raising `start` with an opcode and four operand words while `busy` is low. The operands are registered on that edge. `busy` stays high until the one-cycle `done` strobe. At that point `res_re`/`res_im` hold the answer, and they keep it until the next request is accepted. A multiply forms the first pair of partial products, AC and BD, in two registers and subtracts them into the real result. It then forms AD and BC in the same two registers and adds them into the imaginary result.

States and transitions of the sequencer:
- `ST_IDLE`: start with add or subtract goes to `ST_ADD_RE`. Start with multiply goes to `ST_ISS_1`. Start with opcode 3 goes to `ST_FINISH`.
- `ST_ADD_RE` goes to `ST_ADD_IM`, which goes to `ST_FINISH`.
- `ST_ISS_1` goes to `ST_ISS_2`.
- `ST_ISS_2` goes to `ST_WAIT`, or straight to `ST_GRAB_1` if the multiplier has only two stages.
- `ST_WAIT` repeats until the first product leaves the pipeline, then goes to `ST_GRAB_1`.
- `ST_GRAB_1` goes to `ST_GRAB_2`, which goes to `ST_COMB`.
- `ST_COMB` goes back to `ST_ISS_1` after the first pair, or on to `ST_FINISH` after the second pair.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `cplx_serial_alu`

## Requirements
- R1: Opcode 2'b00 (add) gives res_re = A+C and res_im = B+D, where the operands are a = A+Bi (a_re, a_im) and b = C+Di (b_re, b_im).
- R2: Opcode 2'b01 (subtract) gives res_re = A-C and res_im = B-D.
- R3: Opcode 2'b10 (multiply) gives res_re = AC-BD and res_im = AD+BC.
- R4: Opcode 2'b11 gives res_re = res_im = 0, and `done` is high in the cycle right after the accepting edge, so it is sampled high at the next rising edge.
- R5: For add and subtract, `done` is sampled high at the third rising edge after the accepting edge.
- R6: For multiply, `done` is sampled high at rising edge 2*MUL_STAGES+7 after the accepting edge (13 with the default MUL_STAGES=3). A partial product is captured only once it has left the multiplier pipeline.
- R7: `busy` goes high after the accepting edge and stays high up to and including the `done` cycle. `done` lasts exactly one cycle. `start` has no effect while `busy` is high.
- R8: Operands and opcode are registered on the accepting edge. Changes to the inputs during an operation do not change its result.
- R9: While idle, res_re and res_im keep the last result until the next request is accepted.
- R10: Full-range operands, including -2^(DW-1) in every position, give exact results in the 2*DW+1 bit outputs with no overflow.
- R11: During and after reset, `busy` and `done` are low and both results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted on a rising edge while busy is low |
| opcode | input | 2 | 00 add, 01 subtract, 10 multiply, 11 zero result |
| a_re | input | DW | Real part A of the first operand, signed |
| a_im | input | DW | Imaginary part B of the first operand, signed |
| b_re | input | DW | Real part C of the second operand, signed |
| b_im | input | DW | Imaginary part D of the second operand, signed |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle strobe: result valid |
| res_re | output | 2*DW+1 | Real part of the result, signed |
| res_im | output | 2*DW+1 | Imaginary part of the result, signed |

## Verification
The bench builds the block with DW=8 and MUL_STAGES=4. With 8-bit operands the most negative value in every operand position can be exercised, which drives the imaginary part of a product to +32768 and needs the seventeenth result bit. Four multiplier stages make the wait state last two cycles instead of one, so the wait counter has to count rather than just pass through, and the multiply latency becomes 15 edges. Requests are also issued with start held high and the operands scrambled while busy, so any accidental re-acceptance or late operand sampling shows up.

// File: rtl/cplx_alu_pkg.sv
package cplx_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_NOP = 2'b11
    } cplx_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADD_RE,
        ST_ADD_IM,
        ST_ISS_1,
        ST_ISS_2,
        ST_WAIT,
        ST_GRAB_1,
        ST_GRAB_2,
        ST_COMB,
        ST_FINISH
    } seq_state_e;

    // Control word driven by the sequencer each cycle
    typedef struct packed {
        logic ld_ops;       // register operands and opcode
        logic clr_res;      // zero both results
        logic mul_issue;    // a product enters the multiplier
        logic mul_x_im;     // multiplier x: 0 = A, 1 = B
        logic mul_y_im;     // multiplier y: 0 = C, 1 = D
        logic alu_from_pp;  // adder sources: 0 = operands, 1 = partial products
        logic alu_im;       // operand adder sources: 0 = real parts, 1 = imaginary
        logic alu_sub;      // adder computes x - y
        logic ld_pp0;       // capture multiplier output into partial 0
        logic ld_pp1;       // capture multiplier output into partial 1
        logic ld_re;        // capture adder output into real result
        logic ld_im;        // capture adder output into imaginary result
    } ctl_t;

endpackage

// File: rtl/cplx_pipe_mult.sv
module cplx_pipe_mult #(
    parameter int DW     = 8,
    parameter int STAGES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic signed [DW-1:0]     x,
    input  logic signed [DW-1:0]     y,
    output logic signed [2*DW-1:0]   prod,
    output logic                     prod_vld
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] raw;
    logic signed [PW-1:0] stage_d [STAGES];
    logic                 stage_v [STAGES];

    // Single signed multiplier; the register chain behind it can be retimed into it
    assign raw = x * y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_d[i] <= '0;
                stage_v[i] <= 1'b0;
            end
        end else begin
            stage_d[0] <= raw;
            stage_v[0] <= issue;
            for (int i = 1; i < STAGES; i++) begin
                stage_d[i] <= stage_d[i-1];
                stage_v[i] <= stage_v[i-1];
            end
        end
    end

    assign prod     = stage_d[STAGES-1];
    assign prod_vld = stage_v[STAGES-1];

endmodule

// File: rtl/cplx_addsub.sv
module cplx_addsub #(
    parameter int RW = 17
) (
    input  logic signed [RW-1:0] x,
    input  logic signed [RW-1:0] y,
    input  logic                 sub,
    output logic signed [RW-1:0] sum
);
    logic signed [RW-1:0] y_eff;

    // One carry chain: subtraction by inverting y and injecting a carry
    always_comb begin
        y_eff = sub ? ~y : y;
        sum   = x + y_eff + {{(RW-1){1'b0}}, sub};
    end

endmodule

// File: rtl/cplx_seq_ctrl.sv
module cplx_seq_ctrl
    import cplx_alu_pkg::*;
#(
    parameter int MUL_STAGES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] opcode,
    output ctl_t       ctl,
    output logic [1:0] cur_op,
    output logic       busy,
    output logic       done
);
    localparam int WAIT_CYC = MUL_STAGES - 2;
    localparam int CW       = $clog2(MUL_STAGES) + 1;
    localparam logic [CW-1:0] WAIT_LOAD = CW'((WAIT_CYC > 0) ? (WAIT_CYC - 1) : 0);

    seq_state_e state_q, state_d;
    cplx_op_e   op_q;
    logic       second_q;
    logic [CW-1:0] wait_q;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && start;

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_ADD;
            second_q <= 1'b0;
            wait_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q     <= cplx_op_e'(opcode);
                second_q <= 1'b0;
            end
            if (state_q == ST_COMB) begin
                second_q <= 1'b1;
            end
            if (state_q == ST_ISS_2) begin
                wait_q <= WAIT_LOAD;
            end else if (state_q == ST_WAIT) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (cplx_op_e'(opcode))
                        OP_ADD, OP_SUB: state_d = ST_ADD_RE;
                        OP_MUL:         state_d = ST_ISS_1;
                        default:        state_d = ST_FINISH;
                    endcase
                end
            end
            ST_ADD_RE: state_d = ST_ADD_IM;
            ST_ADD_IM: state_d = ST_FINISH;
            ST_ISS_1:  state_d = ST_ISS_2;
            ST_ISS_2:  state_d = (WAIT_CYC > 0) ? ST_WAIT : ST_GRAB_1;
            ST_WAIT:   state_d = (wait_q == '0) ? ST_GRAB_1 : ST_WAIT;
            ST_GRAB_1: state_d = ST_GRAB_2;
            ST_GRAB_2: state_d = ST_COMB;
            ST_COMB:   state_d = second_q ? ST_FINISH : ST_ISS_1;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output logic: control word, busy and done
    always_comb begin
        ctl  = '0;
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FINISH);
        unique case (state_q)
            ST_IDLE: begin
                ctl.ld_ops  = start;
                ctl.clr_res = start && (cplx_op_e'(opcode) == OP_NOP);
            end
            ST_ADD_RE: begin
                ctl.alu_sub = (op_q == OP_SUB);
                ctl.ld_re   = 1'b1;
            end
            ST_ADD_IM: begin
                ctl.alu_im  = 1'b1;
                ctl.alu_sub = (op_q == OP_SUB);
                ctl.ld_im   = 1'b1;
            end
            ST_ISS_1: begin
                // AC on the first pair, AD on the second
                ctl.mul_issue = 1'b1;
                ctl.mul_x_im  = 1'b0;
                ctl.mul_y_im  = second_q;
            end
            ST_ISS_2: begin
                // BD on the first pair, BC on the second
                ctl.mul_issue = 1'b1;
                ctl.mul_x_im  = 1'b1;
                ctl.mul_y_im  = !second_q;
            end
            ST_GRAB_1: ctl.ld_pp0 = 1'b1;
            ST_GRAB_2: ctl.ld_pp1 = 1'b1;
            ST_COMB: begin
                ctl.alu_from_pp = 1'b1;
                ctl.alu_sub     = !second_q;
                ctl.ld_re       = !second_q;
                ctl.ld_im       = second_q;
            end
            default: ;
        endcase
    end

    assign cur_op = op_q;

    // R7: done is a single-cycle strobe followed by idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7: once busy, it only drops after a done cycle
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R4: opcode 3 finishes right after acceptance
    p_nop_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (opcode == 2'b11)) |=> done);

    // R5: add and subtract end three edges after acceptance
    p_addsub_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_ADD || op_q == OP_SUB)) |-> $past(start && !busy, 3));

endmodule

// File: rtl/cplx_serial_alu.sv
module cplx_serial_alu
    import cplx_alu_pkg::*;
#(
    parameter int DW         = 8,
    parameter int MUL_STAGES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               opcode,
    input  logic signed [DW-1:0]     a_re,
    input  logic signed [DW-1:0]     a_im,
    input  logic signed [DW-1:0]     b_re,
    input  logic signed [DW-1:0]     b_im,
    output logic                     busy,
    output logic                     done,
    output logic signed [2*DW:0]     res_re,
    output logic signed [2*DW:0]     res_im
);
    localparam int PW = 2 * DW;
    localparam int RW = 2 * DW + 1;

    ctl_t       ctl;
    logic [1:0] cur_op;

    logic signed [DW-1:0] ar_q, ai_q, br_q, bi_q;
    logic signed [PW-1:0] pp0_q, pp1_q;
    logic signed [RW-1:0] re_q, im_q;

    logic signed [DW-1:0] mul_x, mul_y;
    logic signed [PW-1:0] prod;
    logic                 prod_vld;
    logic signed [DW-1:0] opnd_x, opnd_y;
    logic signed [RW-1:0] alu_x, alu_y, alu_sum;

    cplx_seq_ctrl #(
        .MUL_STAGES (MUL_STAGES)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .opcode (opcode),
        .ctl    (ctl),
        .cur_op (cur_op),
        .busy   (busy),
        .done   (done)
    );

    // Operand multiplexers into the shared multiplier
    always_comb begin
        mul_x = ctl.mul_x_im ? ai_q : ar_q;
        mul_y = ctl.mul_y_im ? bi_q : br_q;
    end

    cplx_pipe_mult #(
        .DW     (DW),
        .STAGES (MUL_STAGES)
    ) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (ctl.mul_issue),
        .x        (mul_x),
        .y        (mul_y),
        .prod     (prod),
        .prod_vld (prod_vld)
    );

    // Operand multiplexers into the shared adder/subtracter
    always_comb begin
        opnd_x = ctl.alu_im ? ai_q : ar_q;
        opnd_y = ctl.alu_im ? bi_q : br_q;
        if (ctl.alu_from_pp) begin
            alu_x = {{(RW-PW){pp0_q[PW-1]}}, pp0_q};
            alu_y = {{(RW-PW){pp1_q[PW-1]}}, pp1_q};
        end else begin
            alu_x = {{(RW-DW){opnd_x[DW-1]}}, opnd_x};
            alu_y = {{(RW-DW){opnd_y[DW-1]}}, opnd_y};
        end
    end

    cplx_addsub #(
        .RW (RW)
    ) u_addsub (
        .x   (alu_x),
        .y   (alu_y),
        .sub (ctl.alu_sub),
        .sum (alu_sum)
    );

    // Operand, partial-product and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q  <= '0;
            ai_q  <= '0;
            br_q  <= '0;
            bi_q  <= '0;
            pp0_q <= '0;
            pp1_q <= '0;
            re_q  <= '0;
            im_q  <= '0;
        end else begin
            if (ctl.ld_ops) begin
                ar_q <= a_re;
                ai_q <= a_im;
                br_q <= b_re;
                bi_q <= b_im;
            end
            if (ctl.ld_pp0) pp0_q <= prod;
            if (ctl.ld_pp1) pp1_q <= prod;
            if (ctl.clr_res) begin
                re_q <= '0;
                im_q <= '0;
            end else begin
                if (ctl.ld_re) re_q <= alu_sum;
                if (ctl.ld_im) im_q <= alu_sum;
            end
        end
    end

    assign res_re = re_q;
    assign res_im = im_q;

    // R6: partial products are taken only when the pipeline presents a valid one
    p_grab_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_pp0 || ctl.ld_pp1) |-> prod_vld);

    // R8: registered operands do not move during an operation
    p_ops_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ar_q) && $stable(ai_q) && $stable(br_q) && $stable(bi_q)));

    // R4: opcode 3 reports zero results
    p_nop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_op == 2'b11)) |-> (res_re == '0 && res_im == '0));

    // R9: results hold while idle and no request arrives
    p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_re) && $stable(res_im)));

endmodule

// File: tb/cplx_serial_alu_test.sv
`timescale 1ns/1ps
module cplx_serial_alu_test;
    localparam int DW      = 8;
    localparam int STG     = 4;
    localparam int RW      = 2 * DW + 1;
    localparam int MUL_LAT = 2 * (STG + 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] opcode = 2'b00;
    logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic busy, done;
    logic signed [RW-1:0] res_re, res_im;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    cplx_serial_alu #(.DW(DW), .MUL_STAGES(STG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .busy(busy), .done(done), .res_re(res_re), .res_im(res_im)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, advanced on each rising edge
    bit    m_busy = 0, m_done = 0, m_have = 0;
    int    m_cnt = 0;
    int    exp_re = 0, exp_im = 0;
    string m_tag = "R1", m_lat_tag = "R5", cur_tag = "";

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_have = 0; exp_re = 0; exp_im = 0;
        end else if (!m_busy) begin
            if (start) begin
                int ar, ai, br, bi;
                ar = int'(a_re); ai = int'(a_im); br = int'(b_re); bi = int'(b_im);
                case (opcode)
                    2'b00: begin exp_re = ar + br; exp_im = ai + bi; m_cnt = 2;
                                 m_tag = "R1"; m_lat_tag = "R5"; end
                    2'b01: begin exp_re = ar - br; exp_im = ai - bi; m_cnt = 2;
                                 m_tag = "R2"; m_lat_tag = "R5"; end
                    2'b10: begin exp_re = ar*br - ai*bi; exp_im = ar*bi + ai*br;
                                 m_cnt = MUL_LAT; m_tag = "R3"; m_lat_tag = "R6"; end
                    default: begin exp_re = 0; exp_im = 0; m_cnt = 0;
                                 m_tag = "R4"; m_lat_tag = "R4"; end
                endcase
                if (cur_tag != "") m_tag = cur_tag;
                m_busy = 1;
                m_done = (m_cnt == 0);
            end
        end else if (m_done) begin
            m_busy = 0; m_done = 0; m_have = 1;
        end else begin
            m_cnt--;
            m_done = (m_cnt == 0);
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R7", "busy", int'(busy), int'(m_busy));
            check(m_lat_tag, "done", int'(done), int'(m_done));
            if (m_done) begin
                check(m_tag, "res_re", int'(res_re), exp_re);
                check(m_tag, "res_im", int'(res_im), exp_im);
            end else if (!m_busy && m_have) begin
                check("R9", "res_re held", int'(res_re), exp_re);
                check("R9", "res_im held", int'(res_im), exp_im);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_op(input logic [1:0] op, input int ar, input int ai,
                         input int br, input int bi, input bit scramble, input string tag);
        @(negedge clk);
        opcode = op;
        a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
        cur_tag = tag;
        start = 1'b1;
        @(negedge clk);
        if (!scramble) start = 1'b0;
        while (m_busy) begin
            if (scramble) begin
                // R7/R8: request held and inputs moving while busy
                opcode = 2'($urandom);
                a_re = DW'($urandom); a_im = DW'($urandom);
                b_re = DW'($urandom); b_im = DW'($urandom);
            end
            @(negedge clk);
        end
        start = 1'b0;
        cur_tag = "";
    endtask

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11", "busy in reset", int'(busy), 0);
        check("R11", "done in reset", int'(done), 0);
        check("R11", "res_re in reset", int'(res_re), 0);
        check("R11", "res_im in reset", int'(res_im), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "busy after reset", int'(busy), 0);
        check("R11", "res_re after reset", int'(res_re), 0);

        do_op(2'b00, 3, 4, 5, -2, 0, "R1");
        do_op(2'b00, -7, 100, -9, 27, 0, "R1");
        do_op(2'b01, 3, 4, 5, -2, 0, "R2");
        do_op(2'b01, -128, 127, 127, -128, 0, "R2");
        do_op(2'b10, 3, 4, 5, -2, 0, "R3");
        do_op(2'b10, -1, 0, 0, -1, 0, "R3");
        do_op(2'b11, 55, -3, 9, 12, 0, "R4");
        do_op(2'b10, -128, -128, -128, -128, 0, "R10");
        do_op(2'b10, -128, 127, -128, -128, 0, "R10");
        do_op(2'b10, 127, -128, 127, 127, 0, "R10");
        do_op(2'b00, -128, -128, -128, -128, 0, "R10");
        do_op(2'b01, -128, 127, 127, -128, 0, "R10");
        do_op(2'b10, 17, -5, 33, 21, 1, "R8");
        do_op(2'b00, 1, 2, 3, 4, 1, "R8");
        do_op(2'b11, 1, 2, 3, 4, 1, "R8");
        repeat (5) @(negedge clk);

        for (int k = 0; k < 400; k++) begin
            do_op(2'($urandom), int'($signed(DW'($urandom))), int'($signed(DW'($urandom))),
                  int'($signed(DW'($urandom))), int'($signed(DW'($urandom))),
                  bit'($urandom_range(0, 3) == 0), "");
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule